// File: doc/BRIEF.md
# Floating-Point Exception Capture Unit

This unit sits next to a floating-point pipeline and records what support software needs to finish an instruction that raised a potential exception. It watches the issue stream and always remembers the most recently issued instruction word. When the pipeline pulses the exception input, the unit captures two words in one clock edge. The first is the faulting instruction. The second is the instruction issued before it, which has already retired and has to be completed in software.

Both saved words are rewritten so that they execute unconditionally. When the faulting instruction is a short vector, its register fields are moved forward to name the registers of the iteration that faulted. A status word is filled in at the same edge. It holds a valid bit, a code for the number of vector iterations still to run, and four potential-exception flags. Each flag is qualified by the mode and trap-enable inputs.

After a capture, all three registers are frozen. They stay frozen until software writes the status word with its valid bit cleared. Software reaches the registers through a simple access port. The two instruction registers on that port answer only to privileged accesses.

Top module: `fpexc_capture`

## Requirements
- R1: A synchronous reset sets the status, primary and secondary registers to zero.
- R2: On capture, bits [31:28] of both the primary and the secondary word become 4'b1110, whatever condition field was issued.
- R3: On capture, the primary word is exc_word. When exc_vec is 1, it is changed as follows. Let off = (exc_iter * vec_stride) mod 8. Fields [14:12] and [18:16] each have off added modulo 8. Field [2:0] also has off added when exc_srcb_vec is 1. The secondary word is the last iss_word accepted before the capture cycle.
- R4: Let n = vec_len_m1 - exc_iter when exc_vec is 1 and vec_len_m1 > exc_iter; otherwise n = 0. Status bits [10:8] hold n-1 for n in 1..7 and 3'b111 for n = 0.
- R5: Status bit 7 is set on capture when (mode_ftz is 0 and opnd_subnorm is 1) or (mode_dnan is 0 and opnd_nan is 1).
- R6: Status bit 3 is set on capture when mode_ftz is 0 and pot_uf is 1.
- R7: Status bit 2 is set on capture only when trap_of_en is 1, mode_fast is 0 and pot_of is 1. Status bit 0 follows the same rule with trap_io_en and pot_io.
- R8: Status bit 31 is the exception-valid bit and is set by a capture. Bits [6:4] and bit 1 always read as zero. So do bits [30:11]. A status write keeps only bits 31, [10:7], 3, 2 and 0.
- R9: While status bit 31 is 1, exc_pulse is ignored. If exc_pulse arrives with bit 31 at 0, the capture takes precedence over an access write in the same cycle.
- R10: An access to address 1 or 2 while priv is 0 has three effects in the same cycle. It reads zero, it does not write, and it raises acc_err.
- R11: Address map: 0 is status (open to any mode), 1 is primary, 2 is secondary, and 3 reads zero and ignores writes. A privileged write to address 1 or 2 stores acc_wdata unchanged. acc_rdata is zero when no read is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | An instruction is issued this cycle |
| iss_word | input | 32 | Issued instruction word |
| exc_pulse | input | 1 | Single-cycle potential-exception pulse |
| exc_word | input | 32 | Instruction that raised the exception |
| exc_vec | input | 1 | Faulting instruction is a short vector |
| exc_srcb_vec | input | 1 | Second source operand is a vector |
| exc_iter | input | 3 | Zero-based index of the faulting iteration |
| vec_len_m1 | input | 3 | Vector length minus one |
| vec_stride | input | 2 | Register step per iteration |
| opnd_subnorm | input | 1 | An operand is subnormal |
| opnd_nan | input | 1 | An operand is a NaN |
| pot_uf | input | 1 | Potential underflow detected |
| pot_of | input | 1 | Potential overflow detected |
| pot_io | input | 1 | Potential invalid operation detected |
| mode_ftz | input | 1 | Flush-to-zero mode |
| mode_dnan | input | 1 | Default-NaN mode |
| mode_fast | input | 1 | Fast mode |
| trap_of_en | input | 1 | Overflow trap enable |
| trap_io_en | input | 1 | Invalid-operation trap enable |
| priv | input | 1 | Current access is privileged |
| acc_en | input | 1 | Register access strobe |
| acc_wr | input | 1 | Access is a write |
| acc_addr | input | 2 | Register address |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational |
| acc_err | output | 1 | Non-privileged access to an instruction register |

## Verification
The bench covers the edges of the iteration code. A faulting final iteration must give 3'b111. A length-eight vector faulting on its first iteration must give 3'b110. An off-by-one encoding would swap or shift these codes.

Random strides and iteration indices push the register-field adjustment past 7. A design that carries into the neighbouring field instead of wrapping within the three bits then corrupts the saved word. Each exception cycle also issues a new word. A design that captures that word, rather than the earlier one, fails the secondary-word compare.

The bench also covers the remaining corners. It sends second exceptions while the registers are frozen. It writes the status word in the same cycle as a capture. It makes unprivileged reads and writes. A design that overwrites frozen state, lets the clear win over a capture, or leaks instruction data to user mode shows a wrong register value.

// File: rtl/fpexc_capture.sv
module fpexc_capture #(
  parameter int XLEN  = 32,
  parameter int RFLD  = 3,
  parameter logic [3:0] ALWAYS_COND = 4'b1110,
  parameter logic [XLEN-1:0] STAT_WMASK = 32'h8000_078D
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            iss_valid,
  input  logic [XLEN-1:0] iss_word,
  input  logic            exc_pulse,
  input  logic [XLEN-1:0] exc_word,
  input  logic            exc_vec,
  input  logic            exc_srcb_vec,
  input  logic [2:0]      exc_iter,
  input  logic [2:0]      vec_len_m1,
  input  logic [1:0]      vec_stride,
  input  logic            opnd_subnorm,
  input  logic            opnd_nan,
  input  logic            pot_uf,
  input  logic            pot_of,
  input  logic            pot_io,
  input  logic            mode_ftz,
  input  logic            mode_dnan,
  input  logic            mode_fast,
  input  logic            trap_of_en,
  input  logic            trap_io_en,
  input  logic            priv,
  input  logic            acc_en,
  input  logic            acc_wr,
  input  logic [1:0]      acc_addr,
  input  logic [XLEN-1:0] acc_wdata,
  output logic [XLEN-1:0] acc_rdata,
  output logic            acc_err
);
  localparam int PW = RFLD + 2;

  logic [XLEN-1:0] prim_q, sec_q, stat_q, last_q, prim_adj;

  wire valid   = stat_q[XLEN-1];
  wire capture = exc_pulse && !valid;

  wire [PW-1:0]   prod = PW'(exc_iter) * PW'(vec_stride);
  wire [RFLD-1:0] step = prod[RFLD-1:0];

  wire [2:0] remain    = (exc_vec && vec_len_m1 > exc_iter) ? vec_len_m1 - exc_iter : 3'd0;
  wire [2:0] iter_code = remain - 3'd1;

  wire f_in = (!mode_ftz && opnd_subnorm) || (!mode_dnan && opnd_nan);
  wire f_uf = !mode_ftz && pot_uf;
  wire f_of = trap_of_en && !mode_fast && pot_of;
  wire f_io = trap_io_en && !mode_fast && pot_io;

  wire [XLEN-1:0] cap_stat = {1'b1, {(XLEN-12){1'b0}}, iter_code, f_in, 3'b000, f_uf, f_of, 1'b0, f_io};

  always_comb begin
    prim_adj = exc_word;
    prim_adj[XLEN-1 -: 4] = ALWAYS_COND;
    if (exc_vec) begin
      prim_adj[12 +: RFLD] = exc_word[12 +: RFLD] + step;
      prim_adj[16 +: RFLD] = exc_word[16 +: RFLD] + step;
      if (exc_srcb_vec) prim_adj[0 +: RFLD] = exc_word[0 +: RFLD] + step;
    end
  end

  wire priv_reg = (acc_addr == 2'd1) || (acc_addr == 2'd2);
  wire acc_ok   = acc_en && (priv || !priv_reg);
  wire wr_ok    = acc_ok && acc_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      prim_q <= '0;
      sec_q  <= '0;
      stat_q <= '0;
      last_q <= '0;
    end else begin
      if (iss_valid) last_q <= iss_word;
      if (capture) begin
        prim_q <= prim_adj;
        sec_q  <= {ALWAYS_COND, last_q[XLEN-5:0]};
        stat_q <= cap_stat;
      end else if (wr_ok) begin
        case (acc_addr)
          2'd0:    stat_q <= acc_wdata & STAT_WMASK;
          2'd1:    prim_q <= acc_wdata;
          2'd2:    sec_q  <= acc_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    acc_rdata = '0;
    if (acc_ok && !acc_wr) begin
      case (acc_addr)
        2'd0:    acc_rdata = stat_q;
        2'd1:    acc_rdata = prim_q;
        2'd2:    acc_rdata = sec_q;
        default: acc_rdata = '0;
      endcase
    end
  end

  assign acc_err = acc_en && priv_reg && !priv;
endmodule

// File: rtl/fpexc_capture_chk.sv
module fpexc_capture_chk (
  input logic        clk,
  input logic        rst,
  input logic        exc_pulse,
  input logic        exc_vec,
  input logic        trap_of_en,
  input logic        priv,
  input logic        acc_en,
  input logic [1:0]  acc_addr,
  input logic [31:0] acc_rdata,
  input logic        acc_err,
  input logic [31:0] prim_q,
  input logic [31:0] sec_q,
  input logic [31:0] stat_q
);
  assert_cond_forced_R2: assert property (@(posedge clk) disable iff (rst)
    exc_pulse && !stat_q[31] |=> prim_q[31:28] == 4'b1110 && sec_q[31:28] == 4'b1110);

  assert_iter_none_R4: assert property (@(posedge clk) disable iff (rst)
    exc_pulse && !stat_q[31] && !exc_vec |=> stat_q[10:8] == 3'b111);

  assert_of_gated_R7: assert property (@(posedge clk) disable iff (rst)
    exc_pulse && !stat_q[31] && !trap_of_en |=> !stat_q[2]);

  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (rst)
    stat_q[6:4] == 3'b000 && !stat_q[1]);

  assert_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    exc_pulse && stat_q[31] && !acc_en |=> $stable(prim_q) && $stable(sec_q) && $stable(stat_q));

  assert_user_blocked_R10: assert property (@(posedge clk) disable iff (rst)
    acc_en && !priv && (acc_addr == 2'd1 || acc_addr == 2'd2) |-> acc_err && acc_rdata == 32'd0);
endmodule

bind fpexc_capture fpexc_capture_chk u_chk (
  .clk(clk), .rst(rst), .exc_pulse(exc_pulse), .exc_vec(exc_vec),
  .trap_of_en(trap_of_en), .priv(priv), .acc_en(acc_en), .acc_addr(acc_addr),
  .acc_rdata(acc_rdata), .acc_err(acc_err),
  .prim_q(prim_q), .sec_q(sec_q), .stat_q(stat_q)
);

// File: tb/fpexc_capture_test.sv
`timescale 1ns/1ps
module fpexc_capture_test;
  logic clk = 0, rst = 1;
  logic iss_valid = 0, exc_pulse = 0, exc_vec = 0, exc_srcb_vec = 0;
  logic [31:0] iss_word = 0, exc_word = 0, acc_wdata = 0;
  logic [2:0] exc_iter = 0, vec_len_m1 = 0;
  logic [1:0] vec_stride = 0, acc_addr = 0;
  logic opnd_subnorm = 0, opnd_nan = 0, pot_uf = 0, pot_of = 0, pot_io = 0;
  logic mode_ftz = 0, mode_dnan = 0, mode_fast = 0, trap_of_en = 0, trap_io_en = 0;
  logic priv = 1, acc_en = 0, acc_wr = 0;
  logic [31:0] acc_rdata;
  logic acc_err;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] prev_iss = 0, e_prim = 0, e_sec = 0, e_stat = 0;

  always #2.5 clk = ~clk;

  fpexc_capture uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_prim(logic [31:0] w, logic v, logic sb, int it, int st);
    logic [31:0] r = w;
    int off = (it * st) % 8;
    r[31:28] = 4'b1110;
    if (v) begin
      r[14:12] = 3'((int'(w[14:12]) + off) % 8);
      r[18:16] = 3'((int'(w[18:16]) + off) % 8);
      if (sb) r[2:0] = 3'((int'(w[2:0]) + off) % 8);
    end
    return r;
  endfunction

  function automatic logic [31:0] m_stat();
    int n = (exc_vec && vec_len_m1 > exc_iter) ? int'(vec_len_m1) - int'(exc_iter) : 0;
    logic [2:0] code = (n == 0) ? 3'b111 : 3'(n - 1);
    logic fi = (!mode_ftz && opnd_subnorm) || (!mode_dnan && opnd_nan);
    logic fu = !mode_ftz && pot_uf;
    logic fo = trap_of_en && !mode_fast && pot_of;
    logic fv = trap_io_en && !mode_fast && pot_io;
    return {1'b1, 20'd0, code, fi, 3'b000, fu, fo, 1'b0, fv};
  endfunction

  task automatic issue(logic [31:0] w);
    @(negedge clk); iss_valid = 1; iss_word = w;
    @(posedge clk); #1 iss_valid = 0; prev_iss = w;
  endtask

  task automatic rnd_exc_inputs();
    exc_word = $urandom; exc_vec = 1'($urandom); exc_srcb_vec = 1'($urandom);
    exc_iter = 3'($urandom); vec_len_m1 = 3'($urandom); vec_stride = 2'($urandom);
    {opnd_subnorm, opnd_nan, pot_uf, pot_of, pot_io} = 5'($urandom);
    {mode_ftz, mode_dnan, mode_fast, trap_of_en, trap_io_en} = 5'($urandom);
  endtask

  task automatic fire(logic with_iss, logic [31:0] iw);
    @(negedge clk);
    exc_pulse = 1;
    iss_valid = with_iss; iss_word = iw;
    if (!e_stat[31]) begin
      e_prim = m_prim(exc_word, exc_vec, exc_srcb_vec, exc_iter, vec_stride);
      e_sec = {4'b1110, prev_iss[27:0]};
      e_stat = m_stat();
    end
    @(posedge clk); #1 exc_pulse = 0; iss_valid = 0;
    if (with_iss) prev_iss = iw;
  endtask

  task automatic rd(logic [1:0] a, logic p, output logic [31:0] d, output logic e);
    @(negedge clk); acc_en = 1; acc_wr = 0; acc_addr = a; priv = p;
    #1 d = acc_rdata; e = acc_err;
    @(posedge clk); #1 acc_en = 0; priv = 1;
  endtask

  task automatic wr(logic [1:0] a, logic p, logic [31:0] v, output logic e);
    @(negedge clk); acc_en = 1; acc_wr = 1; acc_addr = a; priv = p; acc_wdata = v;
    #1 e = acc_err;
    @(posedge clk); #1 acc_en = 0; acc_wr = 0; priv = 1;
  endtask

  task automatic check_all(string tag);
    logic [31:0] d; logic e;
    rd(2'd0, 1, d, e); chk({tag, " status"}, d, e_stat);
    rd(2'd1, 1, d, e); chk({tag, " primary"}, d, e_prim);
    rd(2'd2, 1, d, e); chk({tag, " secondary"}, d, e_sec);
  endtask

  task automatic clear();
    logic e;
    wr(2'd0, 1, 32'd0, e); e_stat = 0;
  endtask

  initial begin
    logic [31:0] d; logic e;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rst = 0;
    check_all("R1 reset");

    for (int i = 0; i < 300; i++) begin
      issue($urandom);
      if (i % 3 == 0) issue($urandom);
      rnd_exc_inputs();
      fire(1'($urandom), $urandom);
      check_all("R2 R3 R4 R5 R6 R7 R8 capture");
      if (i % 4 == 0) begin
        rnd_exc_inputs();
        fire(0, 0);
        check_all("R9 frozen");
      end
      clear();
      rd(2'd0, 1, d, e); chk("R9 clear", d, 32'd0);
    end

    issue(32'h0123_4567);
    rnd_exc_inputs(); exc_vec = 1; vec_len_m1 = 3'd7; exc_iter = 3'd0;
    fire(0, 0);
    rd(2'd0, 1, d, e); chk("R4 seven remain", 32'(d[10:8]), 32'd6);
    clear();
    rnd_exc_inputs(); exc_vec = 1; vec_len_m1 = 3'd3; exc_iter = 3'd3;
    fire(0, 0);
    rd(2'd0, 1, d, e); chk("R4 last iteration", 32'(d[10:8]), 32'd7);
    clear();

    rnd_exc_inputs(); exc_vec = 1; exc_srcb_vec = 1; exc_iter = 3'd7; vec_stride = 2'd3;
    exc_word = 32'h0007_7007;
    fire(0, 0);
    check_all("R3 wrap");
    clear();

    rnd_exc_inputs(); exc_vec = 0; pot_of = 1; trap_of_en = 1; mode_fast = 1;
    pot_io = 1; trap_io_en = 1;
    fire(0, 0);
    rd(2'd0, 1, d, e); chk("R7 fast mode", 32'(d[2:0]), 32'd0);
    clear();

    rnd_exc_inputs();
    @(negedge clk);
    exc_pulse = 1; acc_en = 1; acc_wr = 1; acc_addr = 0; acc_wdata = 0;
    e_prim = m_prim(exc_word, exc_vec, exc_srcb_vec, exc_iter, vec_stride);
    e_sec = {4'b1110, prev_iss[27:0]}; e_stat = m_stat();
    @(posedge clk); #1 exc_pulse = 0; acc_en = 0; acc_wr = 0;
    check_all("R9 capture beats write");

    rd(2'd1, 0, d, e); chk("R10 user read", d, 32'd0); chk("R10 user err", 32'(e), 32'd1);
    wr(2'd2, 0, 32'hDEAD_BEEF, e); chk("R10 user write err", 32'(e), 32'd1);
    rd(2'd2, 1, d, e); chk("R10 write ignored", d, e_sec); chk("R10 no err priv", 32'(e), 32'd0);
    rd(2'd0, 0, d, e); chk("R11 status user", d, e_stat);
    wr(2'd1, 1, 32'h5A5A_1234, e); e_prim = 32'h5A5A_1234;
    rd(2'd1, 1, d, e); chk("R11 priv write", d, e_prim);
    wr(2'd3, 1, 32'hFFFF_FFFF, e);
    rd(2'd3, 1, d, e); chk("R11 addr3", d, 32'd0);
    wr(2'd0, 1, 32'hFFFF_FFFF, e);
    rd(2'd0, 1, d, e); chk("R8 write mask", d, 32'h8000_078D);
    @(negedge clk); chk("R11 idle rdata", acc_rdata, 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule